// File: doc/BRIEF.md
# Program Counter with Return Stack

This block holds the 13-bit instruction address of a small 14-bit-instruction processor core, together with an 8-entry return-address stack. Each cycle the surrounding core presents at most one control event: a sequential step, a write of the low address byte from the ALU, a jump or call carrying an 11-bit literal, a return, or an interrupt vectoring request. A separate 5-bit upper-address latch supplies the high address bits. A low-byte write takes all five latch bits. A jump or call takes only the top two latch bits.

The fetch address leaves the block reduced modulo the implemented program memory size (256 or 512 words, set by parameter), so any address past the end wraps into the implemented space. The stack is a circular buffer with no overflow or underflow indication. Its pointer cannot be seen or written from outside. All pins are plain control and data strobes sampled on the rising clock. There is no valid/ready handshake: the core issues an event only when it wants it, and the block always accepts it in that cycle.

Top module: `pc_stack_unit`

## Requirements
- R1: While `rst_n` is low, the PC, the upper latch and the stack pointer are cleared, so `fetch_addr` and `latch_q` read 0.
- R2: With `step_en` as the only event, the PC increases by one on the next rising edge.
- R3: A `lo_wr` event loads PC[7:0] from `lo_data` and PC[12:8] from all 5 bits of `latch_q` as it stood before that edge. A `latch_wr` in the same cycle only affects later events.
- R4: A `jmp_go` event loads PC[10:0] from `jmp_lit` and PC[12:11] from `latch_q[4:3]`.
- R5: A `jmp_go` with `jmp_call` high also pushes PC+1 onto the stack.
- R6: An `irq_req` event pushes the current PC, not PC+1, and loads the PC with address 4.
- R7: A `ret_req` event pops the most recent stack entry into the PC. After a call followed at once by a return, the PC is the call address plus one.
- R8: The stack holds 8 entries and wraps. The ninth push overwrites the entry of the first push. A pop with nothing pushed returns whatever entry the wrapped pointer selects, and no flag is raised.
- R9: `latch_q` changes only on a `latch_wr` event, which loads `latch_d`. Pushes and pops leave it unchanged.
- R10: `fetch_addr` equals the PC modulo `MEM_WORDS`. A step from the last implemented word gives `fetch_addr` 0.
- R11: When several events coincide, one wins in this order: `irq_req`, `ret_req`, `jmp_go`, `lo_wr`, `step_en`. With none present, the PC holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Advance to the next sequential address |
| lo_wr | input | 1 | ALU result is written to the low address byte |
| lo_data | input | 8 | ALU result for the low byte |
| jmp_go | input | 1 | Jump or call event |
| jmp_call | input | 1 | With `jmp_go`: also push the return address |
| jmp_lit | input | 11 | Opcode literal target |
| ret_req | input | 1 | Pop the stack into the PC |
| irq_req | input | 1 | Vector to the interrupt address |
| latch_wr | input | 1 | Write the upper-address latch |
| latch_d | input | 5 | New upper-address latch value |
| fetch_addr | output | 13 | PC reduced to the implemented memory size |
| latch_q | output | 5 | Current upper-address latch |

## Verification
The hardest case to reach from the ports is the stack wrap. A pushed entry is only visible again when it is popped, so the overwrite of the oldest entry shows up only after a deep run of pops. The stimulus makes ten nested calls, each to a distinct literal, and then eleven returns. The returned addresses must show that the two oldest entries were replaced, and that popping past empty cycles back through the surviving slots. A same-cycle call and return, and an interrupt coinciding with other events, cover the ordering rules.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [2:0] {
    SRC_HOLD,
    SRC_INC,
    SRC_LOW,
    SRC_JMP,
    SRC_VEC,
    SRC_POP
  } pc_src_e;
endpackage

// File: rtl/pcs_next_sel.sv
module pcs_next_sel
  import pcs_pkg::*;
(
  input  logic    step_en,
  input  logic    lo_wr,
  input  logic    jmp_go,
  input  logic    jmp_call,
  input  logic    ret_req,
  input  logic    irq_req,
  output pc_src_e src,
  output logic    push,
  output logic    pop
);
  // Fixed priority: vector, return, jump/call, low write, step.
  always_comb begin
    src  = SRC_HOLD;
    push = 1'b0;
    pop  = 1'b0;
    if (irq_req) begin
      src  = SRC_VEC;
      push = 1'b1;
    end else if (ret_req) begin
      src = SRC_POP;
      pop = 1'b1;
    end else if (jmp_go) begin
      src  = SRC_JMP;
      push = jmp_call;
    end else if (lo_wr) begin
      src = SRC_LOW;
    end else if (step_en) begin
      src = SRC_INC;
    end
  end
endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_val,
  output logic [W-1:0] top_val
);
  localparam int SP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [SP_W-1:0] LAST = SP_W'(DEPTH - 1);

  logic [W-1:0]    mem [DEPTH];
  logic [SP_W-1:0] sp;
  logic [SP_W-1:0] sp_inc;
  logic [SP_W-1:0] sp_dec;

  // Circular pointer arithmetic, valid for any depth.
  assign sp_inc  = (sp == LAST) ? '0 : sp + SP_W'(1);
  assign sp_dec  = (sp == '0) ? LAST : sp - SP_W'(1);
  assign top_val = mem[sp_dec];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (push) begin
      mem[sp] <= push_val;
      sp      <= sp_inc;
    end else if (pop) begin
      sp <= sp_dec;
    end
  end
endmodule

// File: rtl/pcs_addr_wrap.sv
module pcs_addr_wrap #(
  parameter int PC_W      = 13,
  parameter int MEM_WORDS = 512
) (
  input  logic [PC_W-1:0] pc,
  output logic [PC_W-1:0] addr
);
  generate
    if (MEM_WORDS >= (1 << PC_W)) begin : g_full
      assign addr = pc;
    end else begin : g_mask
      localparam logic [PC_W-1:0] MASK = PC_W'(MEM_WORDS - 1);
      assign addr = pc & MASK;
    end
  endgenerate
endmodule

// File: rtl/pc_stack_unit.sv
module pc_stack_unit
  import pcs_pkg::*;
#(
  parameter int PC_W      = 13,
  parameter int LIT_W     = 11,
  parameter int DEPTH     = 8,
  parameter int MEM_WORDS = 512,
  parameter int VEC_ADDR  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_en,
  input  logic                lo_wr,
  input  logic [7:0]          lo_data,
  input  logic                jmp_go,
  input  logic                jmp_call,
  input  logic [LIT_W-1:0]    jmp_lit,
  input  logic                ret_req,
  input  logic                irq_req,
  input  logic                latch_wr,
  input  logic [PC_W-9:0]     latch_d,
  output logic [PC_W-1:0]     fetch_addr,
  output logic [PC_W-9:0]     latch_q
);
  localparam int LAT_W = PC_W - 8;
  localparam int JHI_W = PC_W - LIT_W;

  pc_src_e         src;
  logic            push, pop;
  logic [PC_W-1:0] pc, pc_nxt, pc_inc, push_val, stk_top;

  pcs_next_sel u_sel (
    .step_en (step_en),
    .lo_wr   (lo_wr),
    .jmp_go  (jmp_go),
    .jmp_call(jmp_call),
    .ret_req (ret_req),
    .irq_req (irq_req),
    .src     (src),
    .push    (push),
    .pop     (pop)
  );

  assign pc_inc   = pc + PC_W'(1);
  // Interrupts save the interrupted address; calls save the next one.
  assign push_val = (src == SRC_VEC) ? pc : pc_inc;

  pcs_ret_stack #(.DEPTH(DEPTH), .W(PC_W)) u_stack (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (push),
    .pop     (pop),
    .push_val(push_val),
    .top_val (stk_top)
  );

  always_comb begin
    unique case (src)
      SRC_INC: pc_nxt = pc_inc;
      SRC_LOW: pc_nxt = {latch_q, lo_data};
      SRC_JMP: pc_nxt = {latch_q[LAT_W-1 -: JHI_W], jmp_lit};
      SRC_VEC: pc_nxt = PC_W'(VEC_ADDR);
      SRC_POP: pc_nxt = stk_top;
      default: pc_nxt = pc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc      <= '0;
      latch_q <= '0;
    end else begin
      pc <= pc_nxt;
      if (latch_wr) latch_q <= latch_d;
    end
  end

  pcs_addr_wrap #(.PC_W(PC_W), .MEM_WORDS(MEM_WORDS)) u_wrap (
    .pc  (pc),
    .addr(fetch_addr)
  );
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
  parameter int PC_W      = 13,
  parameter int LIT_W     = 11,
  parameter int MEM_WORDS = 512,
  parameter int VEC_ADDR  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step_en,
  input logic             lo_wr,
  input logic [7:0]       lo_data,
  input logic             jmp_go,
  input logic             jmp_call,
  input logic [LIT_W-1:0] jmp_lit,
  input logic             ret_req,
  input logic             irq_req,
  input logic             latch_wr,
  input logic [PC_W-9:0]  latch_d,
  input logic [PC_W-1:0]  fetch_addr,
  input logic [PC_W-9:0]  latch_q
);
  localparam int LAT_W = PC_W - 8;
  localparam int JHI_W = PC_W - LIT_W;
  localparam logic [PC_W-1:0] MASK =
    (MEM_WORDS >= (1 << PC_W)) ? '1 : PC_W'(MEM_WORDS - 1);

  logic            sel_ret, sel_jmp, sel_low, sel_step, sel_call;
  logic [PC_W-1:0] want_low, want_jmp, want_step;

  assign sel_ret   = ret_req && !irq_req;
  assign sel_jmp   = jmp_go && !ret_req && !irq_req;
  assign sel_call  = sel_jmp && jmp_call;
  assign sel_low   = lo_wr && !jmp_go && !ret_req && !irq_req;
  assign sel_step  = step_en && !lo_wr && !jmp_go && !ret_req && !irq_req;
  assign want_low  = {latch_q, lo_data} & MASK;
  assign want_jmp  = {latch_q[LAT_W-1 -: JHI_W], jmp_lit} & MASK;
  assign want_step = (fetch_addr + PC_W'(1)) & MASK;

  always_ff @(negedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (fetch_addr == '0 && latch_q == '0)
        else $error("reset state not clear");
    end
  end

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_step |=> fetch_addr == $past(want_step));

  p_low_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_low |=> fetch_addr == $past(want_low));

  p_jump_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_jmp |=> fetch_addr == $past(want_jmp));

  p_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> fetch_addr == (PC_W'(VEC_ADDR) & MASK));

  p_call_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ret && $past(sel_call)) |=>
      fetch_addr == (($past(fetch_addr, 2) + PC_W'(1)) & MASK));

  p_latch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_wr |=> $stable(latch_q));

  p_latch_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    latch_wr |=> latch_q == $past(latch_d));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_en || lo_wr || jmp_go || ret_req || irq_req) |=> $stable(fetch_addr));
endmodule

bind pc_stack_unit pcs_checker #(
  .PC_W(PC_W), .LIT_W(LIT_W), .MEM_WORDS(MEM_WORDS), .VEC_ADDR(VEC_ADDR)
) u_pcs_chk (
  .clk(clk), .rst_n(rst_n), .step_en(step_en), .lo_wr(lo_wr),
  .lo_data(lo_data), .jmp_go(jmp_go), .jmp_call(jmp_call),
  .jmp_lit(jmp_lit), .ret_req(ret_req), .irq_req(irq_req),
  .latch_wr(latch_wr), .latch_d(latch_d), .fetch_addr(fetch_addr),
  .latch_q(latch_q)
);

// File: tb/pc_stack_unit_test.sv
`timescale 1ns/1ps
module pc_stack_unit_test;
  localparam logic [12:0] MASK = 13'h1FF;

  typedef struct {
    logic [12:0] addr;
    string       tag;
  } exp_t;

  logic        clk = 0, rst_n = 0;
  logic        step_en = 0, lo_wr = 0, jmp_go = 0, jmp_call = 0;
  logic        ret_req = 0, irq_req = 0, latch_wr = 0;
  logic [7:0]  lo_data = 0;
  logic [10:0] jmp_lit = 0;
  logic [4:0]  latch_d = 0;
  logic [12:0] fetch_addr;
  logic [4:0]  latch_q;

  int n_cmp = 0, n_bad = 0;
  exp_t sb[$];

  logic [12:0] m_pc = 0;
  logic [4:0]  m_lat = 0;
  logic [12:0] m_stk [8];
  int          m_sp = 0;

  always #5 clk = ~clk;

  pc_stack_unit uut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .lo_wr(lo_wr),
    .lo_data(lo_data), .jmp_go(jmp_go), .jmp_call(jmp_call),
    .jmp_lit(jmp_lit), .ret_req(ret_req), .irq_req(irq_req),
    .latch_wr(latch_wr), .latch_d(latch_d), .fetch_addr(fetch_addr),
    .latch_q(latch_q)
  );

  task automatic m_push(input logic [12:0] v);
    m_stk[m_sp] = v;
    m_sp = (m_sp + 1) % 8;
  endtask

  // Driver: applies one cycle of events, updates the model, queues the result.
  task automatic drive(input bit s, input bit lw, input logic [7:0] ld,
                       input bit jg, input bit jc, input logic [10:0] lit,
                       input bit rr, input bit iq, input bit lwe,
                       input logic [4:0] ldat, input string tag);
    exp_t e;
    @(negedge clk);
    step_en = s; lo_wr = lw; lo_data = ld; jmp_go = jg; jmp_call = jc;
    jmp_lit = lit; ret_req = rr; irq_req = iq; latch_wr = lwe; latch_d = ldat;
    if (iq) begin
      m_push(m_pc); m_pc = 13'd4;
    end else if (rr) begin
      m_sp = (m_sp + 7) % 8; m_pc = m_stk[m_sp];
    end else if (jg) begin
      if (jc) m_push(m_pc + 13'd1);
      m_pc = {m_lat[4:3], lit};
    end else if (lw) begin
      m_pc = {m_lat, ld};
    end else if (s) begin
      m_pc = m_pc + 13'd1;
    end
    if (lwe) m_lat = ldat;
    @(posedge clk);
    #1;
    e.addr = m_pc & MASK;
    e.tag  = tag;
    sb.push_back(e);
    step_en = 0; lo_wr = 0; jmp_go = 0; jmp_call = 0;
    ret_req = 0; irq_req = 0; latch_wr = 0;
  endtask

  task automatic step(input string tag);
    drive(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic set_latch(input logic [4:0] v);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, v, "R9");
  endtask
  task automatic call(input logic [10:0] lit);
    drive(0, 0, 0, 1, 1, lit, 0, 0, 0, 0, "R5");
  endtask
  task automatic ret(input string tag);
    drive(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, tag);
  endtask

  task automatic check_latch(input logic [4:0] want, input string tag);
    @(negedge clk);
    n_cmp++;
    if (latch_q !== want) begin
      n_bad++;
      $display("FAIL %s latch_q actual %h expected %h", tag, latch_q, want);
    end
  endtask

  // Monitor: compares queued expectations at the falling edge.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_cmp++;
      if (fetch_addr !== e.addr) begin
        n_bad++;
        $display("FAIL %s fetch_addr actual %h expected %h", e.tag, fetch_addr, e.addr);
      end
    end
  end

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_stk[i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state visible at the ports
    n_cmp++;
    if (fetch_addr !== 13'd0 || latch_q !== 5'd0) begin
      n_bad++;
      $display("FAIL R1 fetch/latch actual %h/%h expected 0/0", fetch_addr, latch_q);
    end
    rst_n = 1;
    // R2: sequential steps
    step("R2"); step("R2"); step("R2");
    // R11: idle cycle holds
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
    // R3: low-byte write with all latch bits; same-cycle latch write is late
    set_latch(5'b10110);
    check_latch(5'b10110, "R9");
    drive(0, 1, 8'h34, 0, 0, 0, 0, 0, 1, 5'b00001, "R3");
    drive(0, 1, 8'hFF, 0, 0, 0, 0, 0, 0, 0, "R3");
    // R10: step past the last implemented word wraps to 0
    step("R10");
    // R4: plain jump with latch[4:3] = 2'b00, then with 2'b10
    drive(0, 0, 0, 1, 0, 11'h123, 0, 0, 0, 0, "R4");
    set_latch(5'b10000);
    drive(0, 0, 0, 1, 0, 11'h1F0, 0, 0, 0, 0, "R4");
    // R7: call immediately returned
    call(11'h050);
    ret("R7");
    // R8: ten nested calls then eleven returns (wrap and pop past empty)
    for (int i = 0; i < 10; i++) call(11'(16 * (i + 1) + i));
    check_latch(5'b10000, "R9");
    for (int i = 0; i < 11; i++) ret("R8");
    check_latch(5'b10000, "R9");
    // R6: interrupt saves the interrupted address
    drive(0, 1, 8'h77, 0, 0, 0, 0, 0, 0, 0, "R3");
    drive(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R6");
    step("R2");
    ret("R6");
    // R11: interrupt beats everything, return beats jump, jump beats low write
    drive(1, 1, 8'h11, 1, 1, 11'h222, 1, 1, 0, 0, "R11");
    drive(1, 1, 8'h11, 1, 1, 11'h222, 1, 0, 0, 0, "R11");
    drive(1, 1, 8'h11, 1, 0, 11'h333, 0, 0, 0, 0, "R11");
    drive(1, 1, 8'h5A, 0, 0, 0, 0, 0, 0, 0, "R11");
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule